// File: doc/BRIEF.md
# Paired Transmit/Receive FIFO with Level Interrupts

This block holds two small queues between a register bus and a serial shift engine. The bus writes words into the transmit queue and the engine drains them. The engine fills the receive queue and the bus reads it back. Each queue is eight entries deep by default. Each queue has a programmable trigger level. Comparing that level with the live occupancy gives one interrupt source per direction.

The two trigger fields are encoded differently. The transmit field is an item count: the source is active while occupancy is at or below it, so a value of 0 means "empty". The receive field is a count minus one: the source is active once occupancy reaches the field plus one.

Interrupt enables are changed through two separate one-hot strobes. One strobe sets enable bits and the other clears them. Status flags, sticky error flags and two DMA request lines, each with its own enable, complete the block.

Top module: `dual_fifo_wm`

## Requirements
- R1: After reset both queues are empty, the trigger fields, interrupt enables and DMA enables are zero, and both error flags are clear.
- R2: Each queue returns words in write order, and its read-data port always shows the oldest stored word.
- R3: A transmit write while the queue holds DEPTH words is dropped and sets the sticky `tx_ovf`. `tx_ovf` stays set until `err_clr[0]` is pulsed. An engine pop in the same cycle still removes a word.
- R4: A bus read of the empty receive queue is dropped and sets the sticky `rx_udf`. The occupancy stays zero. `rx_udf` stays set until `err_clr[1]` is pulsed.
- R5: Each status flag follows its queue's occupancy:
  - `tx_empty` is 1 exactly when the transmit count is 0.
  - `tx_not_full` is 1 exactly when the transmit count is below DEPTH.
  - `rx_not_empty` is 1 exactly when the receive count is above 0.
  - `rx_full` is 1 exactly when the receive count equals DEPTH.
  - Neither count ever exceeds DEPTH.
- R6: `tx_lvl_hit` is 1 while the transmit count is less than or equal to the `trig_tx` field.
- R7: `rx_lvl_hit` is 1 while the receive count is greater than or equal to `trig_rx` + 1.
- R8: Interrupt enables use bit 0 for the transmit level and bit 1 for the receive level.
  - A 1 on `ien_set` sets that enable.
  - A 1 on `ien_clr` clears it, and the clear wins when both are 1 for the same bit.
  - Zero bits leave the enables unchanged.
- R9: `irq` is the OR of each enabled source with its current level condition. It is not latched and drops as soon as the condition goes away.
- R10: A write with `dma_we` loads the DMA enables, bit 0 for transmit and bit 1 for receive.
  - `dma_tx_req` is 1 when transmit DMA is enabled and the transmit queue is not full.
  - `dma_rx_req` is 1 when receive DMA is enabled and the receive queue is not empty.
- R11: These cases change neither the data nor the count and set no error flag:
  - an engine pop of the empty transmit queue;
  - an engine push into the full receive queue.
- R12: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Bus write strobe into the transmit queue |
| tx_wdata | input | DW | Bus write data |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| tx_rdata | output | DW | Oldest transmit word |
| rx_push | input | 1 | Engine pushes a received word |
| rx_wdata | input | DW | Received word from the engine |
| rx_rd | input | 1 | Bus read strobe from the receive queue |
| rx_rdata | output | DW | Oldest received word |
| trig_we | input | 1 | Load both trigger fields |
| trig_tx | input | AW | Transmit trigger, item count |
| trig_rx | input | AW | Receive trigger, count minus one |
| ien_set | input | 2 | Write-one-to-set interrupt enables |
| ien_clr | input | 2 | Write-one-to-clear interrupt enables |
| err_clr | input | 2 | Write-one-to-clear: bit 0 `tx_ovf`, bit 1 `rx_udf` |
| dma_we | input | 1 | Load DMA enables |
| dma_en_d | input | 2 | DMA enables, bit 0 transmit, bit 1 receive |
| tx_count | output | AW+1 | Transmit occupancy |
| rx_count | output | AW+1 | Receive occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_not_empty | output | 1 | Receive queue holds data |
| rx_full | output | 1 | Receive queue full |
| tx_lvl_hit | output | 1 | Transmit level condition |
| rx_lvl_hit | output | 1 | Receive level condition |
| irq_en | output | 2 | Current interrupt enables |
| irq | output | 1 | Level interrupt |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Several properties are checked on every cycle:
- occupancy bounds;
- the error flags setting and holding;
- clear-over-set priority and the hold behaviour of the enables;
- the interrupt being low with no enables and high whenever an enabled source is at its extreme;
- the DMA lines never asking for an impossible transfer.

Some behaviour only the bench scenarios can show:
- word ordering through both queues;
- exact trigger boundaries one item either side of each field;
- the interrupt dropping again once a level condition clears;
- dropped operations leaving the data untouched.

// File: rtl/dual_fifo_wm.sv
module dual_fifo_wm #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  input  logic          trig_we,
  input  logic [AW-1:0] trig_tx,
  input  logic [AW-1:0] trig_rx,
  input  logic [1:0]    ien_set,
  input  logic [1:0]    ien_clr,
  input  logic [1:0]    err_clr,
  input  logic          dma_we,
  input  logic [1:0]    dma_en_d,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_empty,
  output logic          tx_not_full,
  output logic          rx_not_empty,
  output logic          rx_full,
  output logic          tx_lvl_hit,
  output logic          rx_lvl_hit,
  output logic [1:0]    irq_en,
  output logic          irq,
  output logic          tx_ovf,
  output logic          rx_udf,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW-1:0] lvl_tx, lvl_rx;
  logic [1:0]    dma_en;
  logic          tx_do_w, tx_do_r, rx_do_w, rx_do_r;

  assign tx_do_w = tx_wr   & (tx_count != FULL);
  assign tx_do_r = tx_pop  & (tx_count != '0);
  assign rx_do_w = rx_push & (rx_count != FULL);
  assign rx_do_r = rx_rd   & (rx_count != '0);

  always_ff @(posedge clk)
    if (tx_do_w) tx_mem[tx_wp] <= tx_wdata;

  always_ff @(posedge clk)
    if (rx_do_w) rx_mem[rx_wp] <= rx_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp    <= '0;
      tx_rp    <= '0;
      tx_count <= '0;
      tx_ovf   <= 1'b0;
    end else begin
      if (tx_do_w) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_do_r) tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_count <= tx_count + {{AW{1'b0}}, tx_do_w} - {{AW{1'b0}}, tx_do_r};
      tx_ovf   <= (tx_ovf & ~err_clr[0]) | (tx_wr & ~tx_not_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_count <= '0;
      rx_udf   <= 1'b0;
    end else begin
      if (rx_do_w) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_do_r) rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_count <= rx_count + {{AW{1'b0}}, rx_do_w} - {{AW{1'b0}}, rx_do_r};
      rx_udf   <= (rx_udf & ~err_clr[1]) | (rx_rd & ~rx_not_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_tx <= '0;
      lvl_rx <= '0;
      irq_en <= '0;
      dma_en <= '0;
    end else begin
      if (trig_we) begin
        lvl_tx <= trig_tx;
        lvl_rx <= trig_rx;
      end
      if (dma_we) dma_en <= dma_en_d;
      irq_en <= (irq_en | ien_set) & ~ien_clr;
    end
  end

  assign tx_rdata     = tx_mem[tx_rp];
  assign rx_rdata     = rx_mem[rx_rp];
  assign tx_empty     = (tx_count == '0);
  assign tx_not_full  = (tx_count != FULL);
  assign rx_not_empty = (rx_count != '0);
  assign rx_full      = (rx_count == FULL);
  assign tx_lvl_hit   = (tx_count <= {1'b0, lvl_tx});
  assign rx_lvl_hit   = (rx_count >  {1'b0, lvl_rx});
  assign irq          = |(irq_en & {rx_lvl_hit, tx_lvl_hit});
  assign dma_tx_req   = dma_en[0] & tx_not_full;
  assign dma_rx_req   = dma_en[1] & rx_not_empty;
endmodule

// File: rtl/dual_fifo_wm_chk.sv
module dual_fifo_wm_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic          rx_rd,
  input logic [1:0]    ien_set,
  input logic [1:0]    ien_clr,
  input logic [1:0]    err_clr,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          tx_ovf,
  input logic          rx_udf,
  input logic [1:0]    irq_en,
  input logic          irq,
  input logic          dma_tx_req,
  input logic          dma_rx_req
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_txcnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= FULL);
  p_rxcnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= FULL);

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_count == FULL) |=> tx_ovf);
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !err_clr[0]) |=> tx_ovf);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_pop && tx_count == FULL) |=> tx_count == FULL);

  p_udf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_count == '0) |=> rx_udf);
  p_udf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_udf && !err_clr[1]) |=> rx_udf);

  p_ien_clr0_r8: assert property (@(posedge clk) disable iff (!rst_n) ien_clr[0] |=> !irq_en[0]);
  p_ien_clr1_r8: assert property (@(posedge clk) disable iff (!rst_n) ien_clr[1] |=> !irq_en[1]);
  p_ien_set0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set[0] && !ien_clr[0]) |=> irq_en[0]);
  p_ien_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set == 2'b00 && ien_clr == 2'b00) |=> $stable(irq_en));

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n) (irq_en == 2'b00) |-> !irq);
  p_irq_txempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[0] && tx_count == '0) |-> irq);
  p_irq_rxfull_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[1] && rx_count == FULL) |-> irq);

  p_dma_tx_r10: assert property (@(posedge clk) disable iff (!rst_n) dma_tx_req |-> tx_count < FULL);
  p_dma_rx_r10: assert property (@(posedge clk) disable iff (!rst_n) dma_rx_req |-> rx_count != '0);

  p_tx_pushpop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_pop && tx_count != '0 && tx_count != FULL) |=> $stable(tx_count));
endmodule

bind dual_fifo_wm dual_fifo_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_pop(tx_pop), .rx_rd(rx_rd),
  .ien_set(ien_set), .ien_clr(ien_clr), .err_clr(err_clr),
  .tx_count(tx_count), .rx_count(rx_count), .tx_ovf(tx_ovf), .rx_udf(rx_udf),
  .irq_en(irq_en), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/dual_fifo_wm_tb.sv
module dual_fifo_wm_tb;
  logic       clk = 0;
  logic       rst_n;
  logic       tx_wr, tx_pop, rx_push, rx_rd, trig_we, dma_we;
  logic [7:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic [2:0] trig_tx, trig_rx;
  logic [1:0] ien_set, ien_clr, err_clr, dma_en_d, irq_en;
  logic [3:0] tx_count, rx_count;
  logic tx_empty, tx_not_full, rx_not_empty, rx_full, tx_lvl_hit, rx_lvl_hit;
  logic irq, tx_ovf, rx_udf, dma_tx_req, dma_rx_req;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dual_fifo_wm u_dut (.*);

  // row: {tx_wr, tx_pop, data, expected count, expected head, expected tx_ovf}
  localparam logic [22:0] TAB [19] = '{
    {1'b1,1'b0,8'hA0,4'd1,8'hA0,1'b0}, {1'b1,1'b0,8'hA1,4'd2,8'hA0,1'b0},
    {1'b1,1'b0,8'hA2,4'd3,8'hA0,1'b0}, {1'b1,1'b0,8'hA3,4'd4,8'hA0,1'b0},
    {1'b1,1'b0,8'hA4,4'd5,8'hA0,1'b0}, {1'b1,1'b0,8'hA5,4'd6,8'hA0,1'b0},
    {1'b1,1'b0,8'hA6,4'd7,8'hA0,1'b0}, {1'b1,1'b0,8'hA7,4'd8,8'hA0,1'b0},
    {1'b1,1'b0,8'hEE,4'd8,8'hA0,1'b1}, {1'b1,1'b1,8'h55,4'd7,8'hA1,1'b1},
    {1'b1,1'b1,8'h66,4'd7,8'hA2,1'b1}, {1'b0,1'b1,8'h00,4'd6,8'hA3,1'b1},
    {1'b0,1'b1,8'h00,4'd5,8'hA4,1'b1}, {1'b0,1'b1,8'h00,4'd4,8'hA5,1'b1},
    {1'b0,1'b1,8'h00,4'd3,8'hA6,1'b1}, {1'b0,1'b1,8'h00,4'd2,8'hA7,1'b1},
    {1'b0,1'b1,8'h00,4'd1,8'h66,1'b1}, {1'b0,1'b1,8'h00,4'd0,8'h00,1'b1},
    {1'b0,1'b1,8'h00,4'd0,8'h00,1'b1}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle();
    tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0; trig_we = 0; dma_we = 0;
    ien_set = 0; ien_clr = 0; err_clr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic rpush(input logic [7:0] d);
    rx_push = 1; rx_wdata = d; step();
  endtask

  task automatic tpush(input logic [7:0] d);
    tx_wr = 1; tx_wdata = d; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    tx_wdata = 0; rx_wdata = 0; trig_tx = 0; trig_rx = 0; dma_en_d = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 errors", {tx_ovf, rx_udf}, 0);
    chk("R5 reset flags", {tx_empty, tx_not_full, rx_not_empty, rx_full}, 4'b1100);
    chk("R6 level at empty", tx_lvl_hit, 1);
    chk("R10 dma idle", {dma_tx_req, dma_rx_req}, 0);

    for (int i = 0; i < 19; i++) begin
      tx_wr = TAB[i][22]; tx_pop = TAB[i][21]; tx_wdata = TAB[i][20:13];
      step();
      chk("R2/R3/R11 tx count", tx_count, TAB[i][12:9]);
      if (TAB[i][12:9] != 0) chk("R2 tx head", tx_rdata, TAB[i][8:1]);
      chk("R3/R11 tx_ovf", tx_ovf, TAB[i][0]);
    end
    chk("R5 tx_empty after drain", tx_empty, 1);

    err_clr = 2'b01; step();
    chk("R3 tx_ovf cleared", tx_ovf, 0);

    trig_we = 1; trig_tx = 3'd2; trig_rx = 3'd2; step();
    tpush(8'h10); tpush(8'h11);
    chk("R6 count 2 level 2", tx_lvl_hit, 1);
    tpush(8'h12);
    chk("R6 count 3 level 2", tx_lvl_hit, 0);
    chk("R9 no enable", irq, 0);
    tx_pop = 1; step();
    chk("R6 back at 2", tx_lvl_hit, 1);
    ien_set = 2'b01; step();
    chk("R8 set bit0", irq_en, 2'b01);
    chk("R9 tx source", irq, 1);
    step();
    chk("R8 zero write holds", irq_en, 2'b01);
    tpush(8'h13);
    chk("R9 irq drops unlatched", irq, 0);
    tx_pop = 1; step();
    chk("R9 irq returns", irq, 1);
    ien_set = 2'b01; ien_clr = 2'b01; step();
    chk("R8 clear wins", irq_en, 2'b00);
    chk("R9 irq off", irq, 0);

    rpush(8'h21); rpush(8'h22);
    chk("R7 count 2 level 2", rx_lvl_hit, 0);
    chk("R5 rx_not_empty", rx_not_empty, 1);
    rpush(8'h23);
    chk("R7 count 3 level 2", rx_lvl_hit, 1);
    ien_set = 2'b10; step();
    chk("R8 set bit1", irq_en, 2'b10);
    chk("R9 rx source", irq, 1);

    dma_we = 1; dma_en_d = 2'b01; step();
    chk("R10 tx dma only", {dma_tx_req, dma_rx_req}, 2'b10);
    dma_we = 1; dma_en_d = 2'b10; step();
    chk("R10 rx dma only", {dma_tx_req, dma_rx_req}, 2'b01);

    chk("R2 rx head", rx_rdata, 8'h21);
    rx_push = 1; rx_wdata = 8'h24; rx_rd = 1; step();
    chk("R12 push+read count", rx_count, 3);
    chk("R2 rx head 22", rx_rdata, 8'h22);
    rx_rd = 1; step();
    chk("R2 rx head 23", rx_rdata, 8'h23);
    rx_rd = 1; step();
    chk("R2 rx head 24", rx_rdata, 8'h24);
    rx_rd = 1; step();
    chk("R5 rx empty", rx_not_empty, 0);
    chk("R10 rx dma off when empty", dma_rx_req, 0);
    chk("R9 irq off after drain", irq, 0);
    rx_rd = 1; step();
    chk("R4 rx_udf set", rx_udf, 1);
    chk("R4 count stays 0", rx_count, 0);
    err_clr = 2'b10; step();
    chk("R4 rx_udf cleared", rx_udf, 0);

    trig_we = 1; trig_tx = 3'd2; trig_rx = 3'd7; step();
    for (int k = 0; k < 7; k++) rpush(8'h30 + 8'(k));
    chk("R7 count 7 level 7", rx_lvl_hit, 0);
    chk("R5 not full at 7", rx_full, 0);
    rpush(8'h37);
    chk("R7 count 8 level 7", rx_lvl_hit, 1);
    chk("R5 rx_full", rx_full, 1);
    rpush(8'h3F);
    chk("R11 full push count", rx_count, 8);
    chk("R11 full push head", rx_rdata, 8'h30);
    chk("R11 no flag", rx_udf, 0);

    rst_n = 0; step(); rst_n = 1; step();
    chk("R1 rx_count after reset", rx_count, 0);
    chk("R1 enables after reset", irq_en, 0);
    chk("R1 dma after reset", {dma_tx_req, dma_rx_req}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule